// File: doc/BRIEF.md
# Bit Interleave, Deinterleave and Lane Parity Unit

This block is a 32-bit bit-manipulation execution unit for a processor datapath. It receives two source operands and a two-bit operation code from the secondary opcode field. A start strobe captures them. One clock edge later it presents a registered result pair and a one-cycle valid strobe. The low result word is always written. The high result word is written only when the write-high flag is set.

Three operations are provided. Interleave weaves the lower halves of the two sources into one word. Deinterleave sorts the even and odd bit positions of the first source into two words. This is the only operation that returns a 64-bit result. Lane parity reduces each byte of the first source to its parity bit and puts that bit at the bottom of the byte. The surrounding pipeline selects registers and decodes the primary opcode. This unit only maps operands to results.

Top module: `bitlane_unit`

## Requirements
- R1: With op = 2'b00 (interleave), result-low bit 2i+1 equals src_a bit i and result-low bit 2i equals src_b bit i, for i = 0..15.
- R2: Interleave ignores bits 31:16 of both sources; changing them does not change any output.
- R3: With op = 2'b01 (deinterleave), result-low bit k equals src_a bit 2k for k = 0..15, and result-low bits 31:16 are zero.
- R4: Deinterleave sets result-high bit k to src_a bit 2k+1 for k = 0..15, clears result-high bits 31:16, and raises hi_wr.
- R5: With op = 2'b10 (lane parity), result-low bits 0, 8, 16 and 24 hold the XOR of src_a bytes 7:0, 15:8, 23:16 and 31:24 respectively.
- R6: In a lane parity result, every result-low bit other than 0, 8, 16 and 24 is zero.
- R7: For interleave and lane parity, res_hi is zero and hi_wr is low.
- R8: valid is high in exactly the cycle after a cycle in which start was sampled high, and low otherwise.
- R9: A synchronous active-low reset clears valid, res_lo, res_hi and hi_wr.
- R10: The unused code op = 2'b11 yields res_lo = 0, res_hi = 0 and hi_wr low, with valid still asserted.
- R11: While start is low, res_lo, res_hi and hi_wr keep their last values, whatever happens on the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Capture strobe for op and sources |
| op | input | 2 | Operation code: 00 interleave, 01 deinterleave, 10 lane parity, 11 unused |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand (interleave only) |
| valid | output | 1 | Result strobe, one cycle after start |
| res_lo | output | 32 | Low result word |
| res_hi | output | 32 | High result word |
| hi_wr | output | 1 | High result word carries data |

## Verification
The bench sends walking ones and pseudo-random words through each operation. It computes the expected words from the bit-position formulas. If the bit order is swapped in interleave, bit 0 shows src_a instead of src_b. Upper source bits leaking into interleave appear once random upper halves are XOR-ed into otherwise identical operands. A parity bit placed off the lane floor, or a stray bit in a lane, shows up on single-bit and all-ones byte patterns. A write-high flag that is stuck high, or high-word data left from a deinterleave, is caught because interleave and parity runs follow deinterleave runs. A valid that is stretched or delayed, or outputs that drift while start is low, are caught by idle cycles with changing inputs and by a reset applied in the middle of the run.

// File: rtl/bitlane_pkg.sv
package bitlane_pkg;

  // Operation code as seen on the secondary opcode field.
  typedef enum logic [1:0] {
    BL_INTERLEAVE   = 2'b00,
    BL_DEINTERLEAVE = 2'b01,
    BL_LANE_PARITY  = 2'b10,
    BL_UNUSED       = 2'b11
  } bl_op_e;

  // Mask of the lane-floor bit positions for a given word and lane width.
  function automatic logic [63:0] lane_floor_mask(input int word_w, input int lane_w);
    logic [63:0] m;
    m = '0;
    for (int l = 0; l < word_w / lane_w; l++) begin
      m[l * lane_w] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/bl_weave.sv
// Interleave: odd result bits from src_a, even result bits from src_b.
module bl_weave #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] odd_src,
  input  logic [DATA_W-1:0] even_src,
  output logic [DATA_W-1:0] woven
);
  localparam int HALF_W = DATA_W / 2;

  for (genvar i = 0; i < HALF_W; i++) begin : g_pair
    assign woven[2*i+1] = odd_src[i];
    assign woven[2*i]   = even_src[i];
  end

endmodule

// File: rtl/bl_unweave.sv
// Deinterleave: even positions to the low word, odd positions to the high word.
module bl_unweave #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] even_out,
  output logic [DATA_W-1:0] odd_out
);
  localparam int HALF_W = DATA_W / 2;

  for (genvar k = 0; k < HALF_W; k++) begin : g_bit
    assign even_out[k] = word_in[2*k];
    assign odd_out[k]  = word_in[2*k+1];
  end
  assign even_out[DATA_W-1:HALF_W] = '0;
  assign odd_out[DATA_W-1:HALF_W]  = '0;

endmodule

// File: rtl/bl_lane_parity.sv
// Per-lane XOR reduction, result at the lowest bit of each lane.
module bl_lane_parity #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] par_out
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign par_out[l*LANE_W] = ^word_in[l*LANE_W +: LANE_W];
    if (LANE_W > 1) begin : g_pad
      assign par_out[l*LANE_W+1 +: LANE_W-1] = '0;
    end
  end

endmodule

// File: rtl/bitlane_unit.sv
module bitlane_unit
  import bitlane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              valid,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi,
  output logic              hi_wr
);

  // Named internal events for the checker.
  logic              cap_fire;
  bl_op_e            op_q;
  bl_op_e            op_sel;

  logic [DATA_W-1:0] woven_w;
  logic [DATA_W-1:0] even_w;
  logic [DATA_W-1:0] odd_w;
  logic [DATA_W-1:0] par_w;

  logic [DATA_W-1:0] nxt_lo;
  logic [DATA_W-1:0] nxt_hi;
  logic              nxt_wr;

  assign cap_fire = start;
  assign op_sel   = bl_op_e'(op);

  bl_weave #(.DATA_W(DATA_W)) u_weave (
    .odd_src  (src_a),
    .even_src (src_b),
    .woven    (woven_w)
  );

  bl_unweave #(.DATA_W(DATA_W)) u_unweave (
    .word_in  (src_a),
    .even_out (even_w),
    .odd_out  (odd_w)
  );

  bl_lane_parity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_parity (
    .word_in (src_a),
    .par_out (par_w)
  );

  always_comb begin
    nxt_lo = '0;
    nxt_hi = '0;
    nxt_wr = 1'b0;
    unique case (op_sel)
      BL_INTERLEAVE:   nxt_lo = woven_w;
      BL_DEINTERLEAVE: begin
        nxt_lo = even_w;
        nxt_hi = odd_w;
        nxt_wr = 1'b1;
      end
      BL_LANE_PARITY:  nxt_lo = par_w;
      default: begin
        nxt_lo = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      res_lo <= '0;
      res_hi <= '0;
      hi_wr  <= 1'b0;
      op_q   <= BL_INTERLEAVE;
    end else begin
      valid <= cap_fire;
      if (cap_fire) begin
        res_lo <= nxt_lo;
        res_hi <= nxt_hi;
        hi_wr  <= nxt_wr;
        op_q   <= op_sel;
      end
    end
  end

endmodule

// File: rtl/bitlane_unit_chk.sv
module bitlane_unit_chk
  import bitlane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_fire,
  input bl_op_e            op_q,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              valid,
  input logic [DATA_W-1:0] res_lo,
  input logic [DATA_W-1:0] res_hi,
  input logic              hi_wr
);
  localparam logic [63:0]       MASK64 = lane_floor_mask(DATA_W, LANE_W);
  localparam logic [DATA_W-1:0] FLOORS = MASK64[DATA_W-1:0];

  AST_VALID_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> valid); // R8

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> !valid); // R8

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> ($stable(res_lo) && $stable(res_hi) && $stable(hi_wr))); // R11

  AST_WR_HI_ONLY_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (hi_wr == (op_q == BL_DEINTERLEAVE))); // R4

  AST_HI_ZERO_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op_q != BL_DEINTERLEAVE) |-> (res_hi == '0)); // R7

  AST_PARITY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op_q == BL_LANE_PARITY) |-> ((res_lo & ~FLOORS) == '0)); // R6

  AST_WEAVE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op_q == BL_INTERLEAVE) |->
      (res_lo[DATA_W-1] == $past(src_a[DATA_W/2-1]) && res_lo[0] == $past(src_b[0]))); // R1

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op_q == BL_UNUSED) |-> (res_lo == '0)); // R10

endmodule

bind bitlane_unit bitlane_unit_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cap_fire (cap_fire),
  .op_q     (op_q),
  .src_a    (src_a),
  .src_b    (src_b),
  .valid    (valid),
  .res_lo   (res_lo),
  .res_hi   (res_hi),
  .hi_wr    (hi_wr)
);

// File: tb/bitlane_unit_test.sv
module bitlane_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        valid;
  logic [31:0] res_lo;
  logic [31:0] res_hi;
  logic        hi_wr;

  int tests = 0;
  int fails = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  bitlane_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .src_a(src_a), .src_b(src_b),
    .valid(valid), .res_lo(res_lo), .res_hi(res_hi), .hi_wr(hi_wr)
  );

  function automatic logic [31:0] x_weave(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    for (int j = 0; j < 32; j++) r[j] = j[0] ? a[j/2] : b[j/2];
    return r;
  endfunction

  function automatic logic [31:0] x_pick(input logic [31:0] x, input int phase);
    logic [31:0] r = '0;
    for (int k = 0; k < 16; k++) r[k] = x[2*k + phase];
    return r;
  endfunction

  function automatic logic [31:0] x_par(input logic [31:0] x);
    logic [31:0] r = '0;
    for (int l = 0; l < 4; l++) r[8*l] = ($countones(x[8*l +: 8]) % 2) == 1;
    return r;
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one operation at a falling edge, check at the next falling edge.
  task automatic run(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] elo, ehi;
    logic        ewr;
    @(negedge clk);
    op = o; src_a = a; src_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    case (o)
      2'b00: begin elo = x_weave(a, b);  ehi = '0;           ewr = 1'b0; end
      2'b01: begin elo = x_pick(a, 0);   ehi = x_pick(a, 1); ewr = 1'b1; end
      2'b10: begin elo = x_par(a);       ehi = '0;           ewr = 1'b0; end
      default: begin elo = '0;           ehi = '0;           ewr = 1'b0; end
    endcase
    check("R8 valid", {31'd0, valid}, 32'd1);
    case (o)
      2'b00: check("R1 weave", res_lo, elo);
      2'b01: check("R3 split low", res_lo, elo);
      2'b10: check("R5 R6 lane parity", res_lo, elo);
      default: check("R10 unused low", res_lo, elo);
    endcase
    if (o == 2'b01) begin
      check("R4 split high", res_hi, ehi);
      check("R4 hi_wr", {31'd0, hi_wr}, {31'd0, ewr});
    end else begin
      check("R7 R10 high zero", res_hi, ehi);
      check("R7 R10 hi_wr low", {31'd0, hi_wr}, {31'd0, ewr});
    end
  endtask

  initial begin : watchdog
    #1_500_000;
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] a, b, lo0, hi0, lo1;
    logic        wr0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset valid", {31'd0, valid}, 32'd0);
    check("R9 reset res_lo", res_lo, '0);
    check("R9 reset res_hi", res_hi, '0);
    check("R9 reset hi_wr", {31'd0, hi_wr}, 32'd0);
    rst_n = 1'b1;

    // Walking ones through all codes
    for (int i = 0; i < 32; i++) begin
      for (int o = 0; o < 4; o++) begin
        run(o[1:0], 32'd1 << i, 32'd1 << (31 - i));
      end
    end
    // Byte lane fills
    for (int p = 0; p < 256; p++) begin
      run(2'b10, {4{p[7:0]}}, '0);
      run(2'b01, {p[7:0], ~p[7:0], p[7:0], ~p[7:0]}, '0);
    end
    // Pseudo-random sweep, alternating ops so stale high words would show
    for (int n = 0; n < 600; n++) begin
      seed = next_rand(seed); a = seed;
      seed = next_rand(seed); b = seed;
      run(2'b01, a, b);
      run(n[0] ? 2'b00 : 2'b10, b, a);
    end

    // R2: upper halves do not matter for interleave
    for (int n = 0; n < 100; n++) begin
      seed = next_rand(seed); a = seed;
      seed = next_rand(seed); b = seed;
      run(2'b00, {16'd0, a[15:0]}, {16'd0, b[15:0]});
      lo0 = res_lo;
      seed = next_rand(seed);
      run(2'b00, {seed[31:16], a[15:0]}, {seed[15:0], b[15:0]});
      check("R2 upper ignored", res_lo, lo0);
      check("R2 upper ignored high", res_hi, '0);
    end

    // R8 and R11: idle cycles with moving inputs
    run(2'b01, 32'hA5C3_0F96, 32'h1);
    lo0 = res_lo; hi0 = res_hi; wr0 = hi_wr;
    for (int n = 0; n < 20; n++) begin
      seed = next_rand(seed);
      src_a = seed; src_b = ~seed; op = seed[1:0];
      @(negedge clk);
      check("R8 no valid when idle", {31'd0, valid}, 32'd0);
      check("R11 hold low", res_lo, lo0);
      check("R11 hold high", res_hi, hi0);
      check("R11 hold hi_wr", {31'd0, hi_wr}, {31'd0, wr0});
    end

    // R8: back-to-back starts give one result per cycle
    @(negedge clk);
    op = 2'b00; src_a = 32'hFFFF; src_b = 32'h0; start = 1'b1;
    @(negedge clk);
    check("R8 back-to-back first valid", {31'd0, valid}, 32'd1);
    check("R1 back-to-back first", res_lo, 32'hAAAA_AAAA);
    op = 2'b00; src_a = 32'h0; src_b = 32'hFFFF;
    @(negedge clk);
    start = 1'b0;
    check("R8 back-to-back second valid", {31'd0, valid}, 32'd1);
    check("R1 back-to-back second", res_lo, 32'h5555_5555);
    @(negedge clk);
    check("R8 pulse ends", {31'd0, valid}, 32'd0);

    // R9: reset in mid-run clears a deinterleave result
    run(2'b01, 32'hFFFF_FFFF, 32'h0);
    lo1 = res_lo;
    check("R4 all ones high", res_hi, 32'h0000_FFFF);
    @(negedge clk);
    rst_n = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 mid reset valid", {31'd0, valid}, 32'd0);
    check("R9 mid reset res_lo", res_lo, '0);
    check("R9 mid reset res_hi", res_hi, '0);
    check("R9 mid reset hi_wr", {31'd0, hi_wr}, 32'd0);
    rst_n = 1'b1;
    run(2'b10, 32'h0101_0100, 32'h0);
    check("R5 mixed lanes", res_lo, 32'h0101_0100);
    if (lo1 == '0) check("R3 all ones low", lo1, 32'h0000_FFFF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule